// File: doc/BRIEF.md
# Serial Memory Command Front End (SPI slave)

This block is the slave-side serial interface of a byte-wide nonvolatile memory. It watches a chip select, a serial clock, a serial data input and an active-low pause input, and drives a serial data output together with a separate output enable. All four serial inputs are brought into the system clock through synchronisers, and their edges are detected there. The system clock must run at least eight times faster than the serial clock.

Each access starts when chip select falls. The first byte is an opcode. Two opcodes are followed by a 16-bit byte address. Memory reads stream bytes out of a registered memory read port with one cycle of latency. Memory writes hand each received byte to a write port. Single-cycle strobes go to the status/protection unit (latch set, latch clear, status write). A start strobe goes to the write sequencer when chip select rises cleanly after data has been received. Whether a write is permitted is decided outside this block.

Top module: `spi_mem_frontend`

## Requirements
- R1: Serial clock modes 0 and 3 both work. Input bits are taken on rising serial-clock edges and output bits change on falling edges. Every byte travels most significant bit first.
- R2: Opcodes have the form 0000_xccc, with bit 3 ignored. ccc=110 pulses `wren_stb` and ccc=100 pulses `wrdi_stb`. ccc=101 is status read, ccc=001 is status write, ccc=011 is memory read and ccc=010 is memory write.
- R3: Any other opcode byte (ccc=000 or 111, or a nonzero upper nibble) makes the block ignore all further input until the next chip-select fall. In that state it issues no strobe and no memory access, and it keeps `so_oe` low.
- R4: After a memory read or write opcode, the block takes two address bytes, high byte first. Only the low `ADDR_W` bits are used and the bits above them are ignored.
- R5: A memory read outputs the addressed byte first and then the bytes that follow it, for as long as the clock runs. After the highest address it continues at address 0. Serial input is ignored during this phase.
- R6: A pause is entered by taking `hold_n` low and left by taking it high, and both changes are acted on only while the serial clock is low. While paused, `so_oe` is low and clock edges and input bits have no effect. The transfer then continues from the same bit.
- R7: If `busy_i` is high when an opcode completes, every opcode except status read is treated as in R3.
- R8: While chip select is high, `so_oe` is low and no strobe or memory access is produced. After reset `so_oe`, all strobes and both memory enables are low.
- R9: During a memory write, each complete data byte produces one `mem_wr_en` pulse carrying that byte. The address starts at the captured address and steps up by one for each byte, wrapping like R5.
- R10: `prog_start` pulses when chip select rises after at least one complete data byte of a memory write or status write, and only if no partial byte is pending. `prog_status` is 1 for a status write and 0 for a memory write.
- R11: A status read outputs the value of `status_i`, sampled again for each byte, for as long as the clock runs.
- R12: A status write pulses `wrsr_stb` once, with the first data byte on `wrsr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| so_data | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for the serial data out pad |
| busy_i | input | 1 | Internal write cycle in progress |
| status_i | input | 8 | Status byte presented by the status unit |
| mem_addr | output | ADDR_W | Memory port address |
| mem_rd_en | output | 1 | Memory read request, data due next cycle |
| mem_rd_data | input | 8 | Memory read data |
| mem_wr_en | output | 1 | Memory write byte strobe |
| mem_wr_data | output | 8 | Memory write byte |
| wren_stb | output | 1 | Set write-enable latch |
| wrdi_stb | output | 1 | Clear write-enable latch |
| wrsr_stb | output | 1 | Status write strobe |
| wrsr_data | output | 8 | Status write value |
| prog_start | output | 1 | Start the write sequencer |
| prog_status | output | 1 | Kind of the started program cycle |

## Verification
The bench builds the block with `ADDR_W` = 10, which gives a 1024-byte array. With that size the wrap from 0x3FF to 0x000 is reached by a read of only three bytes. It also leaves six upper address bits that are ignored, and one test sets them all. The serial clock half period is eight system cycles, so both sync stages and the registered output have time to settle before each sample. Directed tasks cover modes 0 and 3, a pause in the middle of a read, a partial final byte, and the muted states.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_RD, ST_WR, ST_WRSR, ST_STRD, ST_MUTE
  } fe_state_t;

  typedef enum logic [2:0] {
    OP_BAD, OP_WREN, OP_WRDI, OP_RDSR, OP_WRSR, OP_READ, OP_WRITE
  } fe_op_t;

  // Bit 3 of the opcode is a don't-care; upper nibble must be zero.
  function automatic fe_op_t fe_decode(input logic [7:0] b);
    fe_op_t op;
    op = OP_BAD;
    if (b[7:4] == 4'h0) begin
      case (b[2:0])
        3'b110:  op = OP_WREN;
        3'b100:  op = OP_WRDI;
        3'b101:  op = OP_RDSR;
        3'b001:  op = OP_WRSR;
        3'b011:  op = OP_READ;
        3'b010:  op = OP_WRITE;
        default: op = OP_BAD;
      endcase
    end
    return op;
  endfunction

endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
  parameter int         W       = 4,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[g]}};
      else     chain <= {chain[STAGES-2:0], d[g]};
    end
    assign q[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/spi_fe_bitlink.sv
module spi_fe_bitlink #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       si,
  input  logic       hold_n,
  output logic       sel,
  output logic       cs_rise,
  output logic       cs_fall,
  output logic       fall_ev,
  output logic       byte_ev,
  output logic [7:0] byte_val,
  output logic       bit_idle,
  output logic       paused
);
  logic [3:0] synced;
  logic       cs_s, sck_s, si_s, hold_s;
  logic       sck_prev, cs_prev, rise_ev;
  logic [2:0] cnt;
  logic [6:0] shreg;

  spi_fe_sync #(.W(4), .STAGES(STAGES), .RST_VAL(4'b1001)) u_sync (
    .clk(clk), .rst(rst), .d({hold_n, si, sck, cs_n}), .q(synced));

  assign {hold_s, si_s, sck_s, cs_s} = synced;

  assign sel      = !cs_s;
  assign cs_rise  = cs_s && !cs_prev;
  assign cs_fall  = !cs_s && cs_prev;
  assign rise_ev  = sel && !paused && sck_s && !sck_prev;
  assign fall_ev  = sel && !paused && !sck_s && sck_prev;
  assign byte_ev  = rise_ev && (cnt == 3'd7);
  assign byte_val = {shreg, si_s};
  assign bit_idle = (cnt == 3'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_prev <= 1'b0;
      cs_prev  <= 1'b1;
      paused   <= 1'b0;
      cnt      <= 3'd0;
      shreg    <= '0;
    end else begin
      sck_prev <= sck_s;
      cs_prev  <= cs_s;
      if (cs_s) begin
        paused <= 1'b0;
        cnt    <= 3'd0;
      end else begin
        if (!sck_s) paused <= !hold_s;
        if (rise_ev) begin
          shreg <= {shreg[5:0], si_s};
          cnt   <= cnt + 3'd1;
        end
      end
    end
  end

  // R6
  pause_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    paused |=> ($stable(cnt) || cnt == 3'd0));

endmodule

// File: rtl/spi_fe_ctrl.sv
module spi_fe_ctrl
  import spi_fe_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              cs_rise,
  input  logic              cs_fall,
  input  logic              fall_ev,
  input  logic              byte_ev,
  input  logic [7:0]        byte_val,
  input  logic              bit_idle,
  input  logic              paused,
  input  logic              busy_i,
  input  logic [7:0]        status_i,
  input  logic [7:0]        mem_rd_data,
  output logic              so_data,
  output logic              so_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [7:0]        mem_wr_data,
  output logic              wren_stb,
  output logic              wrdi_stb,
  output logic              wrsr_stb,
  output logic [7:0]        wrsr_data,
  output logic              prog_start,
  output logic              prog_status
);
  localparam int HI_W = ADDR_W - 8;
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  fe_state_t         state;
  fe_op_t            op;
  logic [ADDR_W-1:0] addr_q;
  logic [HI_W-1:0]   ahi;
  logic              aphase, is_rd, fetch_req, rd_pend, got_byte, pend_status;
  logic [7:0]        nxt, cur;
  logic [2:0]        ocnt;
  logic              streaming;

  assign op        = fe_decode(byte_val);
  assign streaming = (state == ST_RD) || (state == ST_STRD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; addr_q <= '0; ahi <= '0; aphase <= 1'b0; is_rd <= 1'b0;
      fetch_req <= 1'b0; rd_pend <= 1'b0; got_byte <= 1'b0; pend_status <= 1'b0;
      nxt <= '0; cur <= '0; ocnt <= '0; so_data <= 1'b0; so_oe <= 1'b0;
      mem_addr <= '0; mem_rd_en <= 1'b0; mem_wr_en <= 1'b0; mem_wr_data <= '0;
      wren_stb <= 1'b0; wrdi_stb <= 1'b0; wrsr_stb <= 1'b0; wrsr_data <= '0;
      prog_start <= 1'b0; prog_status <= 1'b0;
    end else begin
      wren_stb   <= 1'b0;
      wrdi_stb   <= 1'b0;
      wrsr_stb   <= 1'b0;
      prog_start <= 1'b0;
      mem_rd_en  <= 1'b0;
      mem_wr_en  <= 1'b0;
      rd_pend    <= mem_rd_en;
      so_oe      <= sel && !paused && streaming;

      if (rd_pend)             nxt <= mem_rd_data;
      if (state == ST_STRD)    nxt <= status_i;

      if (fetch_req) begin
        mem_rd_en <= 1'b1;
        mem_addr  <= addr_q;
        addr_q    <= addr_q + ONE;
        fetch_req <= 1'b0;
      end

      if (fall_ev && streaming) begin
        ocnt <= ocnt + 3'd1;
        if (ocnt == 3'd0) begin
          so_data <= nxt[7];
          cur     <= nxt;
          if (state == ST_RD) fetch_req <= 1'b1;
        end else begin
          so_data <= cur[3'd7 - ocnt];
        end
      end

      if (cs_rise) begin
        prog_start  <= got_byte && bit_idle;
        prog_status <= pend_status;
        got_byte    <= 1'b0;
        pend_status <= 1'b0;
        state       <= ST_IDLE;
      end else if (cs_fall) begin
        state <= ST_OPC;
      end else if (byte_ev) begin
        case (state)
          ST_OPC: begin
            if (busy_i && op != OP_RDSR) state <= ST_MUTE;
            else begin
              case (op)
                OP_WREN:  begin wren_stb <= 1'b1; state <= ST_MUTE; end
                OP_WRDI:  begin wrdi_stb <= 1'b1; state <= ST_MUTE; end
                OP_RDSR:  begin state <= ST_STRD; ocnt <= '0; nxt <= status_i; end
                OP_WRSR:  state <= ST_WRSR;
                OP_READ,
                OP_WRITE: begin state <= ST_ADDR; aphase <= 1'b0; is_rd <= (op == OP_READ); end
                default:  state <= ST_MUTE;
              endcase
            end
          end
          ST_ADDR: begin
            if (!aphase) begin
              ahi    <= byte_val[HI_W-1:0];
              aphase <= 1'b1;
            end else begin
              addr_q <= {ahi, byte_val};
              if (is_rd) begin
                state     <= ST_RD;
                fetch_req <= 1'b1;
                ocnt      <= '0;
              end else begin
                state <= ST_WR;
              end
            end
          end
          ST_WR: begin
            mem_wr_en   <= 1'b1;
            mem_addr    <= addr_q;
            mem_wr_data <= byte_val;
            addr_q      <= addr_q + ONE;
            got_byte    <= 1'b1;
          end
          ST_WRSR: begin
            wrsr_stb    <= 1'b1;
            wrsr_data   <= byte_val;
            got_byte    <= 1'b1;
            pend_status <= 1'b1;
            state       <= ST_MUTE;
          end
          default: ;
        endcase
      end
    end
  end

  // R8
  oe_deselect_chk: assert property (@(posedge clk) disable iff (rst)
    !sel |=> !so_oe);

  // R2
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wren_stb, wrdi_stb, wrsr_stb, prog_start}));

  // R7
  busy_filter_chk: assert property (@(posedge clk) disable iff (rst)
    busy_i |-> !(mem_wr_en || wren_stb || wrdi_stb || wrsr_stb));

  // R3
  mute_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MUTE && $past(state) == ST_MUTE) |-> (!so_oe && !mem_rd_en && !mem_wr_en));

  // R9
  port_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_en && mem_wr_en));

endmodule

// File: rtl/spi_mem_frontend.sv
module spi_mem_frontend #(
  parameter int ADDR_W = 10,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              hold_n,
  output logic              so_data,
  output logic              so_oe,
  input  logic              busy_i,
  input  logic [7:0]        status_i,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd_en,
  input  logic [7:0]        mem_rd_data,
  output logic              mem_wr_en,
  output logic [7:0]        mem_wr_data,
  output logic              wren_stb,
  output logic              wrdi_stb,
  output logic              wrsr_stb,
  output logic [7:0]        wrsr_data,
  output logic              prog_start,
  output logic              prog_status
);
  logic       sel, cs_rise, cs_fall, fall_ev, byte_ev, bit_idle, paused;
  logic [7:0] byte_val;

  spi_fe_bitlink #(.STAGES(STAGES)) u_link (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .sel(sel), .cs_rise(cs_rise), .cs_fall(cs_fall), .fall_ev(fall_ev),
    .byte_ev(byte_ev), .byte_val(byte_val), .bit_idle(bit_idle), .paused(paused));

  spi_fe_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .sel(sel), .cs_rise(cs_rise), .cs_fall(cs_fall),
    .fall_ev(fall_ev), .byte_ev(byte_ev), .byte_val(byte_val), .bit_idle(bit_idle),
    .paused(paused), .busy_i(busy_i), .status_i(status_i), .mem_rd_data(mem_rd_data),
    .so_data(so_data), .so_oe(so_oe), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en), .mem_wr_data(mem_wr_data), .wren_stb(wren_stb),
    .wrdi_stb(wrdi_stb), .wrsr_stb(wrsr_stb), .wrsr_data(wrsr_data),
    .prog_start(prog_start), .prog_status(prog_status));

endmodule

// File: tb/spi_mem_frontend_test.sv
module spi_mem_frontend_test;
  localparam int AW = 10;
  localparam int H  = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, busy_i = 1'b0;
  logic [7:0] status_i = 8'h00;
  logic so_data, so_oe, mem_rd_en, mem_wr_en, wren_stb, wrdi_stb, wrsr_stb, prog_start, prog_status;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_rd_data, mem_wr_data, wrsr_data;

  int n_tests = 0, n_fail = 0;
  int n_wren = 0, n_wrdi = 0, n_wrsr = 0, n_prog = 0, n_oe = 0, n_rd = 0;
  logic last_kind = 1'b0;
  logic [7:0] ram [1024];

  always #10 clk = ~clk;

  spi_mem_frontend #(.ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .so_data(so_data), .so_oe(so_oe), .busy_i(busy_i), .status_i(status_i),
    .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_data(mem_wr_data), .wren_stb(wren_stb),
    .wrdi_stb(wrdi_stb), .wrsr_stb(wrsr_stb), .wrsr_data(wrsr_data),
    .prog_start(prog_start), .prog_status(prog_status));

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 13 + 5) & 255);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 1024; i++) ram[i] <= pat(i);
    end else begin
      if (mem_rd_en) mem_rd_data <= ram[mem_addr];
      if (mem_wr_en) ram[mem_addr] <= mem_wr_data;
      if (wren_stb) n_wren++;
      if (wrdi_stb) n_wrdi++;
      if (wrsr_stb) n_wrsr++;
      if (prog_start) begin n_prog++; last_kind <= prog_status; end
      if (so_oe) n_oe++;
      if (mem_rd_en) n_rd++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_h(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start(input bit m3);
    @(negedge clk); sck = m3; wait_h(H);
    cs_n = 1'b0; wait_h(H);
  endtask

  task automatic stop(input bit m3);
    @(negedge clk);
    if (!m3) begin sck = 1'b0; wait_h(H); end
    cs_n = 1'b1; wait_h(3 * H);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); sck = 1'b0; si = tx[i];
      wait_h(H);
      rx[i] = so_data;
      sck = 1'b1;
      wait_h(H);
    end
  endtask

  task automatic t_reset();
    chk(so_oe == 1'b0, "R8 oe after reset", so_oe, 0);
    chk(!mem_wr_en && !mem_rd_en && !prog_start, "R8 idle after reset", {mem_wr_en, mem_rd_en, prog_start}, 0);
  endtask

  task automatic t_latch_ops();
    logic [7:0] rx;
    int w0, d0;
    w0 = n_wren; d0 = n_wrdi;
    start(0); xfer(8'h06, rx); stop(0);
    chk(n_wren == w0 + 1, "R2 set-latch mode0", n_wren - w0, 1);
    start(1); xfer(8'h0E, rx); stop(1);
    chk(n_wren == w0 + 2, "R1 R2 set-latch bit3 mode3", n_wren - w0, 2);
    start(0); xfer(8'h0C, rx); stop(0);
    chk(n_wrdi == d0 + 1, "R2 clear-latch", n_wrdi - d0, 1);
  endtask

  task automatic t_status_read();
    logic [7:0] rx;
    status_i = 8'hA5;
    start(0); xfer(8'h05, rx);
    xfer(8'hFF, rx); chk(rx == 8'hA5 && so_oe, "R11 status byte 1", rx, 8'hA5);
    status_i = 8'h3C;
    xfer(8'h00, rx); chk(rx == 8'h3C, "R11 status resampled", rx, 8'h3C);
    stop(0);
  endtask

  task automatic t_read_modes();
    logic [7:0] rx;
    start(0); xfer(8'h03, rx); xfer(8'h01, rx); xfer(8'h23, rx);
    xfer(8'h5A, rx); chk(rx == pat(16'h123), "R5 R1 read first byte mode0", rx, pat(16'h123));
    xfer(8'hA5, rx); chk(rx == pat(16'h124), "R5 read next byte", rx, pat(16'h124));
    stop(0);
    start(1); xfer(8'h0B, rx); xfer(8'hFC, rx); xfer(8'h05, rx);
    xfer(8'h00, rx); chk(rx == pat(5), "R4 upper address ignored mode3", rx, pat(5));
    stop(1);
  endtask

  task automatic t_wrap();
    logic [7:0] rx;
    start(0); xfer(8'h03, rx); xfer(8'h03, rx); xfer(8'hFE, rx);
    xfer(8'h00, rx); chk(rx == pat(16'h3FE), "R5 before wrap", rx, pat(16'h3FE));
    xfer(8'h00, rx); chk(rx == pat(16'h3FF), "R5 top address", rx, pat(16'h3FF));
    xfer(8'h00, rx); chk(rx == pat(0), "R5 wrap to zero", rx, pat(0));
    stop(0);
  endtask

  task automatic t_write();
    logic [7:0] rx;
    int p0;
    p0 = n_prog;
    start(0); xfer(8'h02, rx); xfer(8'h00, rx); xfer(8'h40, rx);
    xfer(8'h11, rx); xfer(8'h22, rx); stop(0);
    chk(n_prog == p0 + 1 && last_kind == 1'b0, "R10 start after write", n_prog - p0, 1);
    start(1); xfer(8'h03, rx); xfer(8'h00, rx); xfer(8'h40, rx);
    xfer(8'h00, rx); chk(rx == 8'h11, "R9 first written byte", rx, 8'h11);
    xfer(8'h00, rx); chk(rx == 8'h22, "R9 address stepped", rx, 8'h22);
    stop(1);
  endtask

  task automatic t_partial();
    logic [7:0] rx;
    int p0;
    p0 = n_prog;
    start(0); xfer(8'h02, rx); xfer(8'h00, rx); xfer(8'h80, rx); xfer(8'h77, rx);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); sck = 1'b0; si = 1'b1; wait_h(H); sck = 1'b1; wait_h(H);
    end
    stop(0);
    chk(n_prog == p0, "R10 no start on partial byte", n_prog - p0, 0);
    chk(ram[8'h80] == 8'h77, "R9 complete byte kept", ram[8'h80], 8'h77);
  endtask

  task automatic t_status_write();
    logic [7:0] rx;
    int s0, p0;
    s0 = n_wrsr; p0 = n_prog;
    start(0); xfer(8'h01, rx); xfer(8'h8C, rx); stop(0);
    chk(n_wrsr == s0 + 1 && wrsr_data == 8'h8C, "R12 status write data", wrsr_data, 8'h8C);
    chk(n_prog == p0 + 1 && last_kind == 1'b1, "R10 status program kind", last_kind, 1);
  endtask

  task automatic t_invalid();
    logic [7:0] rx;
    int w0, o0, r0;
    w0 = n_wren; o0 = n_oe; r0 = n_rd;
    start(0); xfer(8'h07, rx); xfer(8'h06, rx); xfer(8'h03, rx); stop(0);
    start(1); xfer(8'h86, rx); xfer(8'h06, rx); stop(1);
    chk(n_wren == w0, "R3 no strobe after bad opcode", n_wren - w0, 0);
    chk(n_oe == o0 && n_rd == r0, "R3 output silent", n_oe - o0, 0);
    status_i = 8'h42;
    start(0); xfer(8'h05, rx); xfer(8'h00, rx); stop(0);
    chk(rx == 8'h42, "R3 recovers on next select", rx, 8'h42);
  endtask

  task automatic t_hold();
    logic [7:0] rx;
    start(0); xfer(8'h03, rx); xfer(8'h02, rx); xfer(8'h00, rx);
    xfer(8'h00, rx); chk(rx == pat(16'h200), "R6 byte before pause", rx, pat(16'h200));
    @(negedge clk); sck = 1'b0; wait_h(H);
    hold_n = 1'b0; wait_h(H);
    chk(so_oe == 1'b0, "R6 oe low in pause", so_oe, 0);
    for (int i = 0; i < 3; i++) begin
      sck = 1'b1; si = ~si; wait_h(H); sck = 1'b0; wait_h(H);
    end
    chk(so_oe == 1'b0, "R6 oe low while clock toggles", so_oe, 0);
    hold_n = 1'b1; wait_h(H);
    chk(so_oe == 1'b1, "R6 oe back after resume", so_oe, 1);
    xfer(8'h00, rx); chk(rx == pat(16'h201), "R6 byte after pause", rx, pat(16'h201));
    stop(0);
  endtask

  task automatic t_busy();
    logic [7:0] rx;
    int w0, o0, r0;
    @(negedge clk); busy_i = 1'b1;
    w0 = n_wren; o0 = n_oe; r0 = n_rd;
    start(0); xfer(8'h06, rx); stop(0);
    start(0); xfer(8'h03, rx); xfer(8'h00, rx); xfer(8'h00, rx); xfer(8'h00, rx); stop(0);
    chk(n_wren == w0, "R7 latch refused while busy", n_wren - w0, 0);
    chk(n_oe == o0 && n_rd == r0, "R7 read refused while busy", n_rd - r0, 0);
    status_i = 8'hFF;
    start(0); xfer(8'h05, rx); xfer(8'h00, rx); stop(0);
    chk(rx == 8'hFF, "R7 status read while busy", rx, 8'hFF);
    @(negedge clk); busy_i = 1'b0;
  endtask

  task automatic t_deselected();
    int w0, o0;
    w0 = n_wren; o0 = n_oe;
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); sck = 1'b0; si = 8'h06 >> i; wait_h(H); sck = 1'b1; wait_h(H);
    end
    @(negedge clk); sck = 1'b0; wait_h(2 * H);
    chk(n_wren == w0 && n_oe == o0, "R8 no effect while deselected", n_wren - w0, 0);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    wait_h(5);
    rst = 1'b0;
    wait_h(5);
    t_reset();
    t_latch_ops();
    t_status_read();
    t_read_modes();
    t_wrap();
    t_write();
    t_partial();
    t_status_write();
    t_invalid();
    t_hold();
    t_busy();
    t_deselected();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule